// File: doc/BRIEF.md
# Chunked video-memory copy engine with pixel-unit collision model

This block copies bytes from a 16-bit system address space into a two-bank video memory in chunks of 16 bytes. A single-cycle `go` strobe loads a start source address, a 13-bit destination offset and a chunk count. The bank select, the double-speed flag and the revision flag are captured with it. After that the engine runs by itself. Each byte takes a two-cycle slot. In the first cycle it reads the system bus, or skips the read for address windows that cannot be fetched, which leaves 0xFF. In the second cycle it writes video memory.

The pixel unit reads video memory through this block. While a transfer is in progress, every pixel-unit read returns 0x00. Such a read also collides with the byte slot it overlaps. Depending on speed mode and revision, a collision either moves the write to the bitwise AND of the destination offset and the pixel-unit offset, or drops it. The destination offset advances regardless. In single-speed mode the engine keeps the bus for two extra cycles at the end of every chunk.

Top module: `hdma_engine`

## Requirements
- R1: After reset `busy`, `chunk_done`, `sys_rd` and `vram_we` are 0.
- R2: `sys_rd` is raised with `sys_addr` equal to the current source address only when that address is below 0x8000 or its bits [15:13] are 101 or 110. Otherwise no read is made and the byte written is 0xFF. The source address increases by one per byte in every case.
- R3: A clean write goes to `vram_waddr = {bank, dst}`, where dst is a 13-bit offset. The offset increments by one per byte and wraps at 0x1FFF.
- R4: A `go` sampled while idle makes the next cycle the read cycle of the first byte. Each byte is one read cycle followed by one write cycle, and `vram_we` is only ever high in write cycles.
- R5: A pixel-unit request made while `busy` is high makes `ppu_rdata` 0x00 in the next cycle and raises no `vram_re`. While idle the request raises `vram_re` at `{vram_bank, ppu_addr}`, and `ppu_rdata` carries `vram_rdata` in the next cycle.
- R6: A pixel-unit request in either cycle of a slot is a collision for that slot. If requests arrive in both cycles, the write-cycle address is used. Collision state does not carry into the next slot.
- R7: A slot with no collision writes the byte at the current offset.
- R8: On a collision in single-speed mode with the revision flag clear, the byte is not written.
- R9: On a collision in double-speed mode, the byte is written at offset `dst & ppu_addr`.
- R10: On a collision in single-speed mode with the revision flag set, the byte is written at `dst & ppu_addr` only if that pixel-unit offset is odd or at least 0x1900. Otherwise it is dropped.
- R11: A chunk ends after the byte whose incremented offset has low four bits equal to 0. The transfer runs `go_len + 1` chunks and then `busy` falls.
- R12: In double-speed mode `chunk_done` is high in the write cycle of the chunk's last byte. In single-speed mode two hold cycles follow that write, with no write, and `chunk_done` is high in the second of them.
- R13: `go` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start strobe, honoured only when idle |
| go_src | input | 16 | Start source address |
| go_dst | input | 13 | Start destination offset |
| go_len | input | 7 | Number of chunks minus one |
| vram_bank | input | 1 | Bank select (latched at start for copies, live for pixel reads) |
| dbl_speed | input | 1 | Double-speed mode, latched at start |
| rev_sel | input | 1 | Revision flag, latched at start |
| sys_rd | output | 1 | System bus read strobe |
| sys_addr | output | 16 | System bus read address |
| sys_rdata | input | 8 | System bus data, valid the cycle after `sys_rd` |
| ppu_req | input | 1 | Pixel-unit read request |
| ppu_addr | input | 13 | Pixel-unit read offset |
| ppu_rdata | output | 8 | Pixel-unit read data, one cycle after the request |
| vram_re | output | 1 | Video memory read enable |
| vram_raddr | output | 14 | Video memory read address {bank, offset} |
| vram_rdata | input | 8 | Video memory read data, one cycle after `vram_re` |
| vram_we | output | 1 | Video memory write enable |
| vram_waddr | output | 14 | Video memory write address {bank, offset} |
| vram_wdata | output | 8 | Video memory write data |
| busy | output | 1 | Transfer in progress |
| chunk_done | output | 1 | One-cycle pulse at the end of each chunk |

## Verification
The bench aims at collisions in the read cycle only, the write cycle only and both cycles. A design that dropped the read-cycle request, or kept the read-cycle address when both cycles collide, would put the byte at the wrong AND address. Directed pixel offsets 0x18FE, 0x18FF and 0x1900 sit on the even/odd and tile-limit edges of the single-speed revision rule, where a wrong comparison would write a byte that should be dropped or the reverse. Start offsets that are not chunk-aligned, and sources that cross from a fetchable window into an unfetchable one, catch a design that counts bytes instead of watching the offset wrap, or that returns stale bus data in place of 0xFF. A `go` pulsed in mid-transfer would visibly restart the pointers if it were not ignored.

// File: rtl/hdma_pkg.sv
package hdma_pkg;

  localparam int SYS_AW = 16;
  localparam logic [7:0] OPEN_BUS = 8'hFF;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_HOLD = 2'd3
  } hdma_st_e;

  // Source windows that can be fetched: low half, and two 8 KiB windows above video memory.
  function automatic logic src_fetchable(input logic [SYS_AW-1:0] a);
    return (a[15] == 1'b0) || (a[15:13] == 3'b101) || (a[15:13] == 3'b110);
  endfunction

endpackage

// File: rtl/hdma_seq.sv
module hdma_seq
  import hdma_pkg::*;
#(
  parameter int OFS_W    = 13,
  parameter int LEN_W    = 7,
  parameter int CHUNK_LG = 4,
  parameter int HOLD_CYC = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic [SYS_AW-1:0]   go_src,
  input  logic [OFS_W-1:0]    go_dst,
  input  logic [LEN_W-1:0]    go_len,
  input  logic                go_bank,
  input  logic                go_dbl,
  input  logic                go_rev,
  output hdma_st_e            st,
  output logic [SYS_AW-1:0]   src,
  output logic [OFS_W-1:0]    dst,
  output logic                bank,
  output logic                dbl,
  output logic                rev,
  output logic                busy,
  output logic                chunk_done
);

  localparam int HOLD_W = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_CYC - 1);

  hdma_st_e          st_q, st_d;
  logic [SYS_AW-1:0] src_q, src_d;
  logic [OFS_W-1:0]  dst_q, dst_d, dst_inc;
  logic [LEN_W-1:0]  left_q, left_d;
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic              bank_q, dbl_q, rev_q;
  logic              cfg_ld, last_byte, hold_end;

  assign dst_inc   = dst_q + 1'b1;
  assign last_byte = (dst_inc[CHUNK_LG-1:0] == '0);
  assign hold_end  = (hold_q == HOLD_LAST);

  always_comb begin
    st_d       = st_q;
    src_d      = src_q;
    dst_d      = dst_q;
    left_d     = left_q;
    hold_d     = hold_q;
    cfg_ld     = 1'b0;
    chunk_done = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (go) begin
          st_d   = ST_RD;
          src_d  = go_src;
          dst_d  = go_dst;
          left_d = go_len;
          cfg_ld = 1'b1;
        end
      end
      ST_RD: st_d = ST_WR;
      ST_WR: begin
        src_d = src_q + 1'b1;
        dst_d = dst_inc;
        if (!last_byte) begin
          st_d = ST_RD;
        end else if (dbl_q) begin
          chunk_done = 1'b1;
          if (left_q == '0) begin
            st_d = ST_IDLE;
          end else begin
            st_d   = ST_RD;
            left_d = left_q - 1'b1;
          end
        end else begin
          st_d   = ST_HOLD;
          hold_d = '0;
        end
      end
      ST_HOLD: begin
        hold_d = hold_q + 1'b1;
        if (hold_end) begin
          chunk_done = 1'b1;
          if (left_q == '0) begin
            st_d = ST_IDLE;
          end else begin
            st_d   = ST_RD;
            left_d = left_q - 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      src_q  <= '0;
      dst_q  <= '0;
      left_q <= '0;
      hold_q <= '0;
      bank_q <= 1'b0;
      dbl_q  <= 1'b0;
      rev_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      src_q  <= src_d;
      dst_q  <= dst_d;
      left_q <= left_d;
      hold_q <= hold_d;
      if (cfg_ld) begin
        bank_q <= go_bank;
        dbl_q  <= go_dbl;
        rev_q  <= go_rev;
      end
    end
  end

  assign st   = st_q;
  assign src  = src_q;
  assign dst  = dst_q;
  assign bank = bank_q;
  assign dbl  = dbl_q;
  assign rev  = rev_q;
  assign busy = (st_q != ST_IDLE);

  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WR) |-> ($past(st_q) == ST_RD)); // R4
  AST_DST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WR) |=> (dst_q == OFS_W'($past(dst_q) + 1'b1))); // R3
  AST_HOLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOLD) |-> !dbl_q); // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_done |=> !chunk_done); // R12
  AST_GO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (go && st_q == ST_RD) |=> (src_q == $past(src_q) && dst_q == $past(dst_q))); // R13

endmodule

// File: rtl/hdma_src_gate.sv
module hdma_src_gate
  import hdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_ph,
  input  logic              wr_ph,
  input  logic [SYS_AW-1:0] src,
  output logic              sys_rd,
  output logic [SYS_AW-1:0] sys_addr,
  input  logic [7:0]        sys_rdata,
  output logic [7:0]        byte_o
);

  logic fetch_now, fetch_q;

  assign fetch_now = src_fetchable(src);
  assign sys_rd    = rd_ph && fetch_now;
  assign sys_addr  = src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_q <= 1'b0;
    end else if (rd_ph) begin
      fetch_q <= fetch_now;
    end
  end

  assign byte_o = fetch_q ? sys_rdata : OPEN_BUS;

  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rd |=> wr_ph); // R4

endmodule

// File: rtl/hdma_conflict.sv
module hdma_conflict #(
  parameter int OFS_W      = 13,
  parameter int TILE_LIMIT = 32'h1900
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_ph,
  input  logic             wr_ph,
  input  logic             ppu_req,
  input  logic [OFS_W-1:0] ppu_addr,
  input  logic [OFS_W-1:0] dst,
  input  logic             dbl,
  input  logic             rev,
  output logic             we,
  output logic [OFS_W-1:0] ofs
);

  localparam logic [OFS_W-1:0] LIMIT = OFS_W'(TILE_LIMIT);

  logic             hit_q;
  logic [OFS_W-1:0] ca_q;
  logic             hit_w;
  logic [OFS_W-1:0] ca_w;
  logic             masked_ok;

  // Collision capture is reloaded in every read cycle, so it starts clear per slot.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      ca_q  <= '0;
    end else if (rd_ph) begin
      hit_q <= ppu_req;
      ca_q  <= ppu_req ? ppu_addr : '0;
    end
  end

  assign hit_w = ppu_req || hit_q;
  assign ca_w  = ppu_req ? ppu_addr : ca_q;

  always_comb begin
    masked_ok = dbl || ca_w[0] || (ca_w >= LIMIT);
    we        = 1'b0;
    ofs       = dst;
    if (wr_ph) begin
      if (!hit_w) begin
        we = 1'b1;
      end else if (dbl || rev) begin
        we  = masked_ok;
        ofs = dst & ca_w;
      end
    end
  end

  AST_DROP_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ph && (ppu_req || hit_q) && !dbl && !rev) |-> !we); // R8
  AST_CLEAN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ph && we && !ppu_req && !hit_q) |-> (ofs == dst)); // R7
  AST_AND_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> ((ofs & ~dst) == '0)); // R9

endmodule

// File: rtl/hdma_engine.sv
module hdma_engine
  import hdma_pkg::*;
#(
  parameter int OFS_W      = 13,
  parameter int LEN_W      = 7,
  parameter int CHUNK_LG   = 4,
  parameter int HOLD_CYC   = 2,
  parameter int TILE_LIMIT = 32'h1900
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [15:0]       go_src,
  input  logic [OFS_W-1:0]  go_dst,
  input  logic [LEN_W-1:0]  go_len,
  input  logic              vram_bank,
  input  logic              dbl_speed,
  input  logic              rev_sel,
  output logic              sys_rd,
  output logic [15:0]       sys_addr,
  input  logic [7:0]        sys_rdata,
  input  logic              ppu_req,
  input  logic [OFS_W-1:0]  ppu_addr,
  output logic [7:0]        ppu_rdata,
  output logic              vram_re,
  output logic [OFS_W:0]    vram_raddr,
  input  logic [7:0]        vram_rdata,
  output logic              vram_we,
  output logic [OFS_W:0]    vram_waddr,
  output logic [7:0]        vram_wdata,
  output logic              busy,
  output logic              chunk_done
);

  hdma_st_e          st;
  logic [15:0]       src;
  logic [OFS_W-1:0]  dst, wofs;
  logic              bank, dbl, rev;
  logic              rd_ph, wr_ph, wr_en;
  logic [7:0]        byte_w;
  logic              ppu_blk_q;

  hdma_seq #(
    .OFS_W(OFS_W), .LEN_W(LEN_W), .CHUNK_LG(CHUNK_LG), .HOLD_CYC(HOLD_CYC)
  ) i_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .go_src(go_src), .go_dst(go_dst),
    .go_len(go_len), .go_bank(vram_bank), .go_dbl(dbl_speed), .go_rev(rev_sel),
    .st(st), .src(src), .dst(dst), .bank(bank), .dbl(dbl), .rev(rev),
    .busy(busy), .chunk_done(chunk_done)
  );

  assign rd_ph = (st == ST_RD);
  assign wr_ph = (st == ST_WR);

  hdma_src_gate i_src (
    .clk(clk), .rst_n(rst_n), .rd_ph(rd_ph), .wr_ph(wr_ph), .src(src),
    .sys_rd(sys_rd), .sys_addr(sys_addr), .sys_rdata(sys_rdata), .byte_o(byte_w)
  );

  hdma_conflict #(.OFS_W(OFS_W), .TILE_LIMIT(TILE_LIMIT)) i_conf (
    .clk(clk), .rst_n(rst_n), .rd_ph(rd_ph), .wr_ph(wr_ph),
    .ppu_req(ppu_req), .ppu_addr(ppu_addr), .dst(dst), .dbl(dbl), .rev(rev),
    .we(wr_en), .ofs(wofs)
  );

  assign vram_we    = wr_en;
  assign vram_waddr = {bank, wofs};
  assign vram_wdata = byte_w;

  // Pixel-unit reads reach memory only while idle; the copy port owns it otherwise.
  assign vram_re    = ppu_req && !busy;
  assign vram_raddr = {vram_bank, ppu_addr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ppu_blk_q <= 1'b0;
    end else begin
      ppu_blk_q <= ppu_req && busy;
    end
  end

  assign ppu_rdata = ppu_blk_q ? 8'h00 : vram_rdata;

  AST_PPU_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ppu_req && busy) |=> (ppu_rdata == 8'h00)); // R5
  AST_WE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    vram_we |-> !vram_re); // R5

endmodule

// File: tb/test_hdma_engine.sv
module test_hdma_engine;

  localparam int CLK_T = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        go;
  logic [15:0] go_src;
  logic [12:0] go_dst;
  logic [6:0]  go_len;
  logic        vram_bank, dbl_speed, rev_sel;
  logic        sys_rd;
  logic [15:0] sys_addr;
  logic [7:0]  sys_rdata;
  logic        ppu_req;
  logic [12:0] ppu_addr;
  logic [7:0]  ppu_rdata;
  logic        vram_re;
  logic [13:0] vram_raddr;
  logic [7:0]  vram_rdata;
  logic        vram_we;
  logic [13:0] vram_waddr;
  logic [7:0]  vram_wdata;
  logic        busy, chunk_done;

  int n_chk = 0;
  int n_bad = 0;
  bit pend_zero = 1'b0;
  logic [7:0] vmem [int];
  logic [7:0] emem [int];

  always #(CLK_T/2) clk = ~clk;

  hdma_engine i_hdma_engine (
    .clk(clk), .rst_n(rst_n), .go(go), .go_src(go_src), .go_dst(go_dst),
    .go_len(go_len), .vram_bank(vram_bank), .dbl_speed(dbl_speed), .rev_sel(rev_sel),
    .sys_rd(sys_rd), .sys_addr(sys_addr), .sys_rdata(sys_rdata),
    .ppu_req(ppu_req), .ppu_addr(ppu_addr), .ppu_rdata(ppu_rdata),
    .vram_re(vram_re), .vram_raddr(vram_raddr), .vram_rdata(vram_rdata),
    .vram_we(vram_we), .vram_waddr(vram_waddr), .vram_wdata(vram_wdata),
    .busy(busy), .chunk_done(chunk_done)
  );

  function automatic logic [7:0] sysf(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic bit fetchable(input logic [15:0] a);
    return (a < 16'h8000) || (a >= 16'hA000 && a < 16'hE000);
  endfunction

  always @(posedge clk) begin
    sys_rdata <= sys_rd ? sysf(sys_addr) : 8'hEE;
    if (vram_re) vram_rdata <= vmem.exists(int'(vram_raddr)) ? vmem[int'(vram_raddr)] : 8'h00;
    if (vram_we) vmem[int'(vram_waddr)] = vram_wdata;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_pend();
    if (pend_zero) check(ppu_rdata == 8'h00, "R5", "blocked pixel read", ppu_rdata, 0);
  endtask

  // mode: 0 none, 1 every cycle, 2 random, 3 read cycles only, 4 write cycles only
  task automatic drive_ppu(input int mode, input int fixed, input int phase,
                           output bit rq, output logic [12:0] a);
    a = (fixed >= 0) ? 13'(fixed) : 13'($urandom);
    case (mode)
      1: rq = 1'b1;
      2: rq = ($urandom % 2) == 0;
      3: rq = (phase == 0);
      4: rq = (phase == 1);
      default: rq = 1'b0;
    endcase
    ppu_req  = rq;
    ppu_addr = rq ? a : 13'($urandom);
  endtask

  task automatic run(input logic [15:0] src, input logic [12:0] dst, input int len,
                     input bit bank, input bit dbl, input bit rev,
                     input int pmode, input int fixed, input bit poke);
    logic [15:0] s;
    logic [12:0] d;
    bit first, last, rq1, rq2, rqh, ew;
    logic [12:0] a1, a2, ah, ca, eo;
    logic [7:0] eb;
    @(negedge clk);
    ppu_req = 1'b0;
    go_src = src; go_dst = dst; go_len = 7'(len);
    vram_bank = bank; dbl_speed = dbl; rev_sel = rev; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    vram_bank = ~bank; dbl_speed = ~dbl; rev_sel = ~rev;
    s = src; d = dst; first = 1'b1;
    for (int c = 0; c <= len; c++) begin
      do begin
        // read cycle
        drive_ppu(pmode, fixed, 0, rq1, a1);
        if (poke && first) begin
          go = 1'b1; go_src = 16'h4321; go_dst = 13'h0AA5; go_len = 7'd9;
        end
        #1;
        check_pend();
        check(busy == 1'b1, "R4", "busy in read cycle", busy, 1);
        check(sys_rd == fetchable(s), "R2", "sys_rd", sys_rd, fetchable(s));
        if (fetchable(s)) check(sys_addr == s, "R2", "sys_addr", sys_addr, s);
        check(vram_we == 1'b0, "R4", "no write in read cycle", vram_we, 0);
        pend_zero = rq1;
        @(negedge clk);
        go = 1'b0;
        // write cycle
        drive_ppu(pmode, fixed, 1, rq2, a2);
        #1;
        check_pend();
        eb = fetchable(s) ? sysf(s) : 8'hFF;
        ca = rq2 ? a2 : a1;
        eo = d;
        if (!(rq1 || rq2)) ew = 1'b1;
        else if (dbl) begin ew = 1'b1; eo = d & ca; end
        else if (rev) begin ew = ca[0] || (ca >= 13'h1900); eo = d & ca; end
        else ew = 1'b0;
        check(vram_we == ew, (rq1 || rq2) ? (dbl ? "R9" : (rev ? "R10" : "R8")) : "R7",
              "write enable", vram_we, ew);
        if (ew && vram_we) begin
          check(vram_waddr == {bank, eo}, (rq1 || rq2) ? "R6" : "R3", "write address",
                vram_waddr, {bank, eo});
          check(vram_wdata == eb, "R2", "write data", vram_wdata, eb);
          emem[int'({bank, eo})] = eb;
        end
        s = s + 1'b1;
        d = d + 1'b1;
        last = (d[3:0] == 4'h0);
        check(chunk_done == (last && dbl), "R12", "done in write cycle", chunk_done, last && dbl);
        pend_zero = rq2;
        first = 1'b0;
        @(negedge clk);
      end while (!last);
      if (!dbl) begin
        for (int h = 0; h < 2; h++) begin
          drive_ppu(pmode, fixed, 2, rqh, ah);
          #1;
          check_pend();
          check(busy == 1'b1 && vram_we == 1'b0, "R12", "hold cycle", {busy, vram_we}, 2);
          check(chunk_done == (h == 1), "R12", "done in hold", chunk_done, h == 1);
          pend_zero = rqh;
          @(negedge clk);
        end
      end
    end
    ppu_req = 1'b0;
    #1;
    check_pend();
    pend_zero = 1'b0;
    check(busy == 1'b0, "R11", "idle after last chunk", busy, 0);
  endtask

  initial begin
    #(CLK_T * 150000);
    check(1'b0, "R4", "watchdog expired", 0, 1);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [12:0] pa;
    void'($urandom(32'd2024));
    rst_n = 1'b0; go = 1'b0; go_src = '0; go_dst = '0; go_len = '0;
    vram_bank = 1'b0; dbl_speed = 1'b0; rev_sel = 1'b0;
    ppu_req = 1'b0; ppu_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(busy == 0 && chunk_done == 0 && sys_rd == 0 && vram_we == 0, "R1",
          "reset outputs", {busy, chunk_done, sys_rd, vram_we}, 0);

    // clean double-speed chunk, aligned
    run(16'h0100, 13'h0000, 0, 1'b0, 1'b1, 1'b0, 0, -1, 1'b0);
    // idle pixel read returns stored byte (R5 passthrough)
    @(negedge clk);
    vram_bank = 1'b0; ppu_req = 1'b1; ppu_addr = 13'h0005;
    #1;
    check(vram_re == 1'b1 && vram_raddr == 14'h0005, "R5", "idle read issued", vram_re, 1);
    @(negedge clk);
    ppu_req = 1'b0;
    #1;
    check(ppu_rdata == emem[5], "R5", "idle read data", ppu_rdata, emem[5]);

    // unaligned start, two chunks, bank 1, single speed
    run(16'hA0F8, 13'h1FF8, 1, 1'b1, 1'b0, 1'b0, 0, -1, 1'b0);
    // source crossing into unfetchable windows
    run(16'h7FF8, 13'h0040, 0, 1'b0, 1'b0, 1'b0, 0, -1, 1'b0);
    run(16'hDFFC, 13'h0123, 0, 1'b0, 1'b1, 1'b0, 0, -1, 1'b0);
    // collisions: dropped, AND-address, revision edges
    run(16'h0200, 13'h0050, 0, 1'b0, 1'b0, 1'b0, 1, -1, 1'b0);
    run(16'h0300, 13'h1F70, 0, 1'b1, 1'b1, 1'b0, 3, -1, 1'b0);
    run(16'h0400, 13'h0FF0, 0, 1'b0, 1'b1, 1'b0, 4, -1, 1'b0);
    run(16'h0500, 13'h1FF0, 0, 1'b0, 1'b0, 1'b1, 3, 'h18FE, 1'b0);
    run(16'h0600, 13'h1FF0, 0, 1'b0, 1'b0, 1'b1, 4, 'h18FF, 1'b0);
    run(16'h0700, 13'h1FF0, 0, 1'b1, 1'b0, 1'b1, 1, 'h1900, 1'b0);
    // go pulsed mid-transfer (R13)
    run(16'hC010, 13'h0300, 1, 1'b0, 1'b1, 1'b0, 0, -1, 1'b1);
    run(16'h1000, 13'h0308, 0, 1'b1, 1'b0, 1'b1, 2, -1, 1'b1);

    // constrained random
    for (int i = 0; i < 24; i++) begin
      logic [15:0] rs;
      rs = 16'($urandom);
      pa = 13'($urandom);
      run(rs, pa, int'($urandom % 3), 1'($urandom), 1'($urandom), 1'($urandom),
          2, -1, 1'($urandom % 4 == 0));
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule